// File: doc/BRIEF.md
# Serial Offset Min-Sum Check Node

This block is the check-node processor of an offset min-sum LDPC decoder. Each layer brings up to sixteen variable-node messages. They arrive as two groups of eight on two accepted input cycles. The block finds three things across the connected lanes: the smallest magnitude, the next-smallest magnitude and the lane that holds the smallest. It also forms the parity of their signs. The first group's partial result is kept in registers and merged with the second group's tree result.

When the second group is accepted, the block lowers both minima by a programmable offset, with a floor at zero. It stores them in an output bank together with each lane's sign and its connection bit. Over the next two cycles it emits the sixteen corrected messages, eight per cycle.

The reduction registers and the output bank are separate. A new layer can therefore be reduced while the previous one is still being emitted. A stream of back-to-back layers flows through with no stall and no gap.

Top module: `cn_minsum_serial`

## Requirements
- R1: A layer is two accepted input cycles (in_valid high): the first carries lanes 0-7 and the second lanes 8-15, with lane j of a group at in_msg[5j+4:5j] in two's complement. The two groups may be separated by idle cycles.
- R2: A lane's magnitude is the absolute value of its message, and the value -16 saturates to magnitude 15.
- R3: A lane whose in_conn bit is 0 counts as magnitude 15 in the minimum search. Its sign is left out of the sign parity, and its output message is 0.
- R4: The output magnitude of the lane that holds the smallest magnitude is max(second minimum - offset, 0). Every other connected lane gets max(first minimum - offset, 0).
- R5: When magnitudes tie, the lowest lane index is taken as the first minimum, and the tied value also becomes the second minimum.
- R6: A connected lane's output sign is the XOR of all connected input signs (bit 4, 1 = negative) with its own sign. A negative result is emitted as the two's complement negation of the magnitude, so a zero magnitude gives 0.
- R7: The offset is the 4-bit value present on the cycle the second group is accepted. The value present on the first group's cycle has no effect.
- R8: In the cycle after the second group is accepted, out_valid is 1 with out_half 0 (lanes 0-7). In the cycle after that, out_valid is 1 with out_half 1 (lanes 8-15).
- R9: Layers supplied on consecutive cycles with no gap are emitted on consecutive cycles with no gap and none lost.
- R10: After reset out_valid is 0 and the next accepted input cycle is taken as a first group.
- R11: If only one lane of a layer is connected, the second minimum is the saturated value 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group present this cycle |
| in_msg | input | 40 | Eight 5-bit signed messages of the current group |
| in_conn | input | 8 | Connection bit per lane of the current group |
| offset | input | 4 | Offset taken on the second-group cycle |
| out_valid | output | 1 | Output group present this cycle |
| out_half | output | 1 | 0 for lanes 0-7, 1 for lanes 8-15 |
| out_msg | output | 40 | Eight 5-bit signed corrected messages |

## Verification
The hardest case to reach from the ports is a new layer finishing on the same cycle that the previous layer's second output group leaves. That is the only moment the output bank is loaded and drained at once. The bench drives runs of layers with no idle cycle between them, so every layer completes exactly on that cycle, and the scoreboard checks that each expected group appears in order with no gap. Ties, a lone connected lane and the -16 saturation are forced with hand-built layers. Every layer presents a different offset on its first group, so that value is shown to have no effect.

// File: rtl/cn_minsum_serial.sv
module cn_minsum_serial #(
  parameter int W    = 5,
  parameter int HALF = 8,
  parameter int OFFW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [HALF*W-1:0]   in_msg,
  input  logic [HALF-1:0]     in_conn,
  input  logic [OFFW-1:0]     offset,
  output logic                out_valid,
  output logic                out_half,
  output logic [HALF*W-1:0]   out_msg
);
  localparam int N  = 2 * HALF;
  localparam int MW = W - 1;
  localparam int IW = $clog2(N);
  localparam int CW = (MW > OFFW) ? MW : OFFW;
  localparam logic [MW-1:0] MAXM = {MW{1'b1}};

  logic              ph_in;
  logic [MW-1:0]     fb_m1, fb_m2;
  logic [IW-1:0]     fb_idx;
  logic              fb_sx;
  logic [HALF-1:0]   sgn_lo, con_lo;

  logic [MW-1:0]     b_m1, b_m2;
  logic [IW-1:0]     b_idx;
  logic              b_sx, b_full, out_ph;
  logic [N-1:0]      b_sgn, b_con;

  logic [MW-1:0]     r1, r2, f1, f2;
  logic [IW-1:0]     ri, fi;
  logic [HALF-1:0]   sgns;
  logic              hx;

  function automatic logic [MW-1:0] corr(input logic [MW-1:0] m, input logic [OFFW-1:0] o);
    logic [CW-1:0] me, oe;
    me = CW'(m);
    oe = CW'(o);
    return (me > oe) ? MW'(me - oe) : '0;
  endfunction

  always_comb begin : reduce
    logic [MW-1:0] t1 [1:2*HALF-1];
    logic [MW-1:0] t2 [1:2*HALF-1];
    logic [IW-1:0] ti [1:2*HALF-1];
    logic [W-1:0]  x, nx;
    logic [MW-1:0] mag;
    for (int j = 0; j < HALF; j++) begin
      x  = in_msg[j*W +: W];
      nx = -x;
      if (!x[W-1])                           mag = x[MW-1:0];
      else if (x == {1'b1, {MW{1'b0}}})      mag = MAXM;
      else                                   mag = nx[MW-1:0];
      if (!in_conn[j]) mag = MAXM;
      sgns[j]     = x[W-1];
      t1[HALF+j]  = mag;
      t2[HALF+j]  = MAXM;
      ti[HALF+j]  = IW'(j) | (ph_in ? IW'(HALF) : '0);
    end
    for (int i = HALF - 1; i >= 1; i--) begin
      if (t1[2*i] <= t1[2*i+1]) begin
        t1[i] = t1[2*i];
        ti[i] = ti[2*i];
        t2[i] = (t2[2*i] < t1[2*i+1]) ? t2[2*i] : t1[2*i+1];
      end else begin
        t1[i] = t1[2*i+1];
        ti[i] = ti[2*i+1];
        t2[i] = (t2[2*i+1] < t1[2*i]) ? t2[2*i+1] : t1[2*i];
      end
    end
    r1 = t1[1];
    r2 = t2[1];
    ri = ti[1];
    hx = ^(sgns & in_conn);
    if (fb_m1 <= r1) begin
      f1 = fb_m1;
      fi = fb_idx;
      f2 = (fb_m2 < r1) ? fb_m2 : r1;
    end else begin
      f1 = r1;
      fi = ri;
      f2 = (r2 < fb_m1) ? r2 : fb_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_in  <= 1'b0;
      fb_m1  <= '0;
      fb_m2  <= '0;
      fb_idx <= '0;
      fb_sx  <= 1'b0;
      sgn_lo <= '0;
      con_lo <= '0;
      b_m1   <= '0;
      b_m2   <= '0;
      b_idx  <= '0;
      b_sx   <= 1'b0;
      b_sgn  <= '0;
      b_con  <= '0;
      b_full <= 1'b0;
      out_ph <= 1'b0;
    end else begin
      if (in_valid && !ph_in) begin
        fb_m1  <= r1;
        fb_m2  <= r2;
        fb_idx <= ri;
        fb_sx  <= hx;
        sgn_lo <= sgns;
        con_lo <= in_conn;
        ph_in  <= 1'b1;
      end else if (in_valid) begin
        b_m1  <= corr(f1, offset);
        b_m2  <= corr(f2, offset);
        b_idx <= fi;
        b_sx  <= fb_sx ^ hx;
        b_sgn <= {sgns, sgn_lo};
        b_con <= {in_conn, con_lo};
        ph_in <= 1'b0;
      end
      if (in_valid && ph_in) begin
        b_full <= 1'b1;
        out_ph <= 1'b0;
      end else if (b_full) begin
        if (out_ph) b_full <= 1'b0;
        out_ph <= ~out_ph;
      end
    end
  end

  always_comb begin : emit
    logic [IW-1:0] k;
    logic [W-1:0]  v;
    for (int j = 0; j < HALF; j++) begin
      k = IW'(j) | (out_ph ? IW'(HALF) : '0);
      v = b_con[k] ? {1'b0, (k == b_idx) ? b_m2 : b_m1} : '0;
      out_msg[j*W +: W] = (b_sx ^ b_sgn[k]) ? -v : v;
    end
  end

  assign out_valid = b_full;
  assign out_half  = out_ph;

  AST_EMIT_PAIR:   assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_half |=> out_valid && out_half); // R8
  AST_PROMPT_OUT:  assert property (@(posedge clk) disable iff (!rst_n) in_valid && ph_in |=> out_valid && !out_half); // R8
  AST_NO_OVERRUN:  assert property (@(posedge clk) disable iff (!rst_n) in_valid && ph_in && out_valid |-> out_half); // R9
  AST_MIN_ORDER:   assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> b_m1 <= b_m2); // R4
  AST_IDLE_AFTER:  assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_half && !(in_valid && ph_in) |=> !out_valid); // R9
endmodule

// File: tb/cn_minsum_serial_bench.sv
module cn_minsum_serial_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] in_msg = '0;
  logic [7:0]  in_conn = '0;
  logic [3:0]  offset = '0;
  logic        out_valid, out_half;
  logic [39:0] out_msg;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [40:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] lf = 32'h1234_5678;

  always #2.5 clk = ~clk;

  cn_minsum_serial u_cn_minsum_serial (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .in_conn(in_conn), .offset(offset), .out_valid(out_valid),
    .out_half(out_half), .out_msg(out_msg)
  );

  function automatic logic [79:0] model(logic [79:0] m, logic [15:0] c, logic [3:0] o);
    int mag[16];
    int m1 = 99, m2 = 99, idx = 0, v, mm;
    bit sx = 0, s;
    logic [79:0] res;
    logic [4:0] r;
    for (int k = 0; k < 16; k++) begin
      v = int'($signed(m[k*5 +: 5]));
      mag[k] = (v < 0) ? -v : v;
      if (mag[k] > 15) mag[k] = 15;
      if (!c[k]) mag[k] = 15;
      else sx ^= m[k*5+4];
    end
    for (int k = 0; k < 16; k++) if (mag[k] < m1) begin m1 = mag[k]; idx = k; end
    for (int k = 0; k < 16; k++) if (k != idx && mag[k] < m2) m2 = mag[k];
    for (int k = 0; k < 16; k++) begin
      mm = (k == idx) ? m2 : m1;
      mm = (mm > int'(o)) ? mm - int'(o) : 0;
      if (!c[k]) mm = 0;
      s = sx ^ m[k*5+4];
      r = 5'(mm);
      res[k*5 +: 5] = s ? -r : r;
    end
    return res;
  endfunction

  task automatic send(input logic [79:0] m, input logic [15:0] c, input logic [3:0] o, input string tag);
    logic [79:0] e;
    e = model(m, c, o);
    @(negedge clk);
    exp_q.push_back({1'b0, e[39:0]});  tag_q.push_back(tag);
    exp_q.push_back({1'b1, e[79:40]}); tag_q.push_back(tag);
    in_valid = 1'b1; in_msg = m[39:0]; in_conn = c[7:0]; offset = ~o;
    @(negedge clk);
    in_msg = m[79:40]; in_conn = c[15:8]; offset = o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic step_lf();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
  endtask

  task automatic rand_frame(input string tag, input bit sparse);
    logic [79:0] m;
    logic [15:0] c;
    logic [3:0]  o;
    for (int k = 0; k < 16; k++) begin
      step_lf();
      m[k*5 +: 5] = lf[4:0];
    end
    step_lf();
    c = sparse ? lf[15:0] : 16'hFFFF;
    o = lf[19:16] & 4'h7;
    send(m, c, o, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected output half=%0d msg=%h expected none", out_half, out_msg);
      end else begin
        logic [40:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_half, out_msg} !== e) begin
          failures++;
          $display("FAIL %s got half=%0d msg=%h expected half=%0d msg=%h", t, out_half, out_msg, e[40], e[39:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [79:0] m;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R10 idle out_valid=%b expected 0", out_valid);
    end

    for (int k = 0; k < 16; k++) m[k*5 +: 5] = 5'(k - 8);
    send(m, 16'hFFFF, 4'd0, "R1/R4/R6");  idle(3);
    send(m, 16'hFFFF, 4'd3, "R7");        idle(3);
    send(m, 16'hFFFF, 4'd15, "R4 floor"); idle(3);

    for (int k = 0; k < 16; k++) m[k*5 +: 5] = 5'b10000;
    m[5*5 +: 5] = 5'd3;
    send(m, 16'hFFFF, 4'd1, "R2");        idle(3);

    for (int k = 0; k < 16; k++) m[k*5 +: 5] = 5'(k[0] ? -1 : 2 + k);
    send(m, 16'h0F0F, 4'd1, "R3");        idle(3);

    for (int k = 0; k < 16; k++) m[k*5 +: 5] = 5'd6;
    m[3*5 +: 5] = 5'd2;  m[11*5 +: 5] = -5'd2;
    send(m, 16'hFFFF, 4'd0, "R5");        idle(3);

    for (int k = 0; k < 16; k++) m[k*5 +: 5] = 5'd1;
    m[9*5 +: 5] = -5'd4;
    send(m, 16'h0200, 4'd2, "R11");       idle(3);

    // half groups separated by idle cycles
    for (int k = 0; k < 16; k++) m[k*5 +: 5] = 5'(3 * k - 20);
    begin
      logic [79:0] e;
      e = model(m, 16'hFFFF, 4'd1);
      @(negedge clk);
      exp_q.push_back({1'b0, e[39:0]});  tag_q.push_back("R1 gap");
      exp_q.push_back({1'b1, e[79:40]}); tag_q.push_back("R1 gap");
      in_valid = 1'b1; in_msg = m[39:0]; in_conn = 8'hFF; offset = 4'd9;
      idle(2);
      @(negedge clk);
      in_valid = 1'b1; in_msg = m[79:40]; in_conn = 8'hFF; offset = 4'd1;
      idle(3);
    end

    for (int f = 0; f < 8; f++) rand_frame("R9", f[0]);
    idle(4);
    for (int f = 0; f < 24; f++) begin
      rand_frame("R4/R6 random", 1'b1);
      idle(f % 3);
    end
    idle(6);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 outstanding=%0d expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule